// File: doc/BRIEF.md
# Stride Two-Delta Value Predictor

This block keeps, for every static instruction, a small record of how its results evolve: the most recent result, the most recent difference between two consecutive results, and a stride that is only trusted once it has been seen twice in succession. Each update carries a partial program counter and the value the instruction actually produced. In return the block reports a value extrapolated a fixed number of dynamic instances ahead, the entry's 2-bit confidence level, and a flag that marks the prediction as trustworthy.

The table is direct-mapped, with no tags, and it is indexed by a slice of the program counter. The consumer uses the high-confidence flag to decide whether to replace the instruction's result with the prediction. A one-cycle clear request, and reset, start a sweep that writes every entry back to zero. While the sweep runs the block reports itself not ready and ignores updates. The table sits in a single synchronous-read memory. A bypass register makes sure that updates to the same entry on consecutive cycles each see the effect of the one before.

Top module: `stride2d_vpred`

## Requirements
- R1: Reset, or a cycle with `clr_i` high, starts a sweep that holds `ready_o` low for exactly 2^IDX_W cycles (4096 by default). The sweep leaves every entry with last value, last delta, stride and confidence all zero. Updates presented while `ready_o` is low are ignored.
- R2: An update is accepted when `upd_valid_i` and `ready_o` are high and `clr_i` is low. `pred_valid_o` is high exactly two rising edges after each accepted update and at no other time.
- R3: The first update to a freshly cleared entry with value v returns prediction v, confidence 0 and the high-confidence flag low.
- R4: The new delta is the actual value minus the entry's last value. The stored stride is replaced by the new delta only if the new delta equals the entry's last delta; otherwise the stride is kept. The last delta always becomes the new delta.
- R5: The prediction equals actual + DIST × stride (DIST = 4 by default), using the stride after this update and wrapping modulo 2^DATA_W. Negative strides use two's complement.
- R6: The confidence counter, held in 2 bits from 0 to 3, rises by one when the actual value equals the entry's last value plus its stride before the update, and falls by one otherwise. It saturates at 3 and at 0, and the returned level is the updated one.
- R7: `pred_hi_o` is high exactly when the returned confidence is at least HI_TH (3 by default).
- R8: The entry index is `upd_pc_i[IDX_LSB +: IDX_W]` (bits 13..2 by default). Program counters that differ only outside these bits share an entry. Entries with different indices do not affect each other.
- R9: Updates to the same entry on back-to-back cycles, or one idle cycle apart, give the same results as widely spaced updates.
- R10: An update presented in the same cycle as `clr_i` produces no prediction and leaves no trace in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts the clearing sweep |
| clr_i | input | 1 | One-cycle request to clear the whole table |
| ready_o | output | 1 | High when updates are accepted (no sweep running) |
| upd_valid_i | input | 1 | Update request |
| upd_pc_i | input | PC_W (16) | Partial program counter of the updating instruction |
| upd_value_i | input | DATA_W (32) | Result the instruction actually produced |
| pred_valid_o | output | 1 | Prediction outputs valid this cycle |
| pred_value_o | output | DATA_W (32) | Value expected DIST instances ahead |
| pred_conf_o | output | 2 | Updated confidence level of the entry |
| pred_hi_o | output | 1 | Confidence at or above the threshold |

## Verification
The bound checker watches the protocol-level behaviour on every cycle: the fixed two-edge latency of `pred_valid_o`, the absence of results after a clear request, the exact sweep length, that each returned confidence is a single saturating step from the entry's previous level, and the agreement of the flag with the level. The arithmetic of the entry (which delta gets committed, the extrapolated value, wraparound, aliasing of program counters and correct handling of same-entry updates on consecutive cycles) can only be shown by the bench. The bench runs trained sequences against its own per-index model and compares every result.

// File: rtl/vp_pkg.sv
package vp_pkg;

  typedef logic [1:0] conf_t;

  localparam conf_t CONF_MAX = 2'd3;
  localparam conf_t CONF_MIN = 2'd0;

  // Saturating up/down step of the confidence counter.
  function automatic conf_t conf_step(input conf_t c, input logic hit);
    conf_t r;
    if (hit) r = (c == CONF_MAX) ? c : c + 2'd1;
    else     r = (c == CONF_MIN) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/vp_table.sv
// Single-port-write, synchronous-read table written for block RAM inference.
module vp_table #(
  parameter int WIDTH = 98,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/vp_clear_seq.sv
// Walks every table address once after reset or a clear request.
module vp_clear_seq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b1;
      addr_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      addr_o <= '0;
    end else if (busy_o) begin
      addr_o <= addr_o + 1'b1;
      if (addr_o == LAST) busy_o <= 1'b0;
    end
  end

  assign we_o = busy_o;
endmodule

// File: rtl/vp_extrap.sv
// base + DIST * stride, modulo 2^W; shift when DIST is a power of two.
module vp_extrap #(
  parameter int W    = 32,
  parameter int DIST = 4
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] stride_i,
  output logic [W-1:0] out_o
);
  localparam bit POW2 = (DIST > 0) && ((DIST & (DIST - 1)) == 0);

  generate
    if (POW2) begin : g_shift
      localparam int SH = $clog2(DIST);
      assign out_o = base_i + (stride_i << SH);
    end else begin : g_mul
      localparam logic [W-1:0] DIST_V = W'(DIST);
      assign out_o = base_i + stride_i * DIST_V;
    end
  endgenerate
endmodule

// File: rtl/vp_entry_update.sv
// Combinational next-state of one table entry plus the returned prediction.
module vp_entry_update
  import vp_pkg::*;
#(
  parameter int W     = 32,
  parameter int DIST  = 4,
  parameter int HI_TH = 3
) (
  input  logic [W-1:0] last_i,
  input  logic [W-1:0] delta_i,
  input  logic [W-1:0] stride_i,
  input  conf_t        conf_i,
  input  logic [W-1:0] actual_i,
  output logic [W-1:0] last_o,
  output logic [W-1:0] delta_o,
  output logic [W-1:0] stride_o,
  output conf_t        conf_o,
  output logic [W-1:0] pred_o,
  output logic         hi_o
);
  logic [W-1:0] diff;
  logic [W-1:0] one_step;
  logic         hit;
  logic         repeat_delta;

  assign diff         = actual_i - last_i;
  assign one_step     = last_i + stride_i;
  assign hit          = (actual_i == one_step);
  assign repeat_delta = (diff == delta_i);

  assign last_o   = actual_i;
  assign delta_o  = diff;
  assign stride_o = repeat_delta ? diff : stride_i;
  assign conf_o   = conf_step(conf_i, hit);
  assign hi_o     = (conf_o >= 2'(HI_TH));

  vp_extrap #(.W(W), .DIST(DIST)) u_extrap (
    .base_i  (actual_i),
    .stride_i(stride_o),
    .out_o   (pred_o)
  );
endmodule

// File: rtl/stride2d_vpred.sv
module stride2d_vpred
  import vp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_W    = 16,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 12,
  parameter int DIST    = 4,
  parameter int HI_TH   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  output logic              ready_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [DATA_W-1:0] upd_value_i,
  output logic              pred_valid_o,
  output logic [DATA_W-1:0] pred_value_o,
  output logic [1:0]        pred_conf_o,
  output logic              pred_hi_o
);
  typedef struct packed {
    logic [DATA_W-1:0] last;
    logic [DATA_W-1:0] delta;
    logic [DATA_W-1:0] stride;
    conf_t             conf;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);

  // Stage 0: accept and address the table
  logic             accept;
  logic [IDX_W-1:0] rd_idx;
  logic             unused_pc;

  // Clear sweep
  logic             sweep_busy;
  logic             sweep_we;
  logic [IDX_W-1:0] sweep_addr;

  // Stage 1: entry read back, updated and written
  logic              s1_v;
  logic [IDX_W-1:0]  s1_idx;
  logic [DATA_W-1:0] s1_act;
  logic              byp_hit;
  entry_t            byp_ent;
  entry_t            rd_ent;
  entry_t            cur_ent;
  entry_t            nxt_ent;
  conf_t             cur_conf;
  logic [DATA_W-1:0] nxt_pred;
  logic              nxt_hi;
  logic [ENT_W-1:0]  rd_raw;

  // Table write port
  logic              tbl_we;
  logic [IDX_W-1:0]  tbl_waddr;
  logic [ENT_W-1:0]  tbl_wdata;

  assign ready_o   = ~sweep_busy;
  assign accept    = upd_valid_i & ready_o & ~clr_i;
  assign rd_idx    = upd_pc_i[IDX_LSB +: IDX_W];
  assign unused_pc = ^upd_pc_i;

  vp_clear_seq #(.AW(IDX_W)) u_clear (
    .clk    (clk),
    .rst    (rst),
    .start_i(clr_i),
    .busy_o (sweep_busy),
    .we_o   (sweep_we),
    .addr_o (sweep_addr)
  );

  // Sweep owns the write port; stage 1 is never valid while it runs.
  assign tbl_we    = sweep_we | s1_v;
  assign tbl_waddr = sweep_we ? sweep_addr : s1_idx;
  assign tbl_wdata = sweep_we ? '0 : nxt_ent;

  vp_table #(.WIDTH(ENT_W), .AW(IDX_W)) u_table (
    .clk    (clk),
    .we_i   (tbl_we),
    .waddr_i(tbl_waddr),
    .wdata_i(tbl_wdata),
    .raddr_i(rd_idx),
    .rdata_o(rd_raw)
  );

  assign rd_ent   = entry_t'(rd_raw);
  // The memory returns stale data when the same entry is written on the read edge.
  assign cur_ent  = byp_hit ? byp_ent : rd_ent;
  assign cur_conf = cur_ent.conf;

  vp_entry_update #(.W(DATA_W), .DIST(DIST), .HI_TH(HI_TH)) u_upd (
    .last_i  (cur_ent.last),
    .delta_i (cur_ent.delta),
    .stride_i(cur_ent.stride),
    .conf_i  (cur_ent.conf),
    .actual_i(s1_act),
    .last_o  (nxt_ent.last),
    .delta_o (nxt_ent.delta),
    .stride_o(nxt_ent.stride),
    .conf_o  (nxt_ent.conf),
    .pred_o  (nxt_pred),
    .hi_o    (nxt_hi)
  );

  always_ff @(posedge clk) begin
    s1_idx  <= rd_idx;
    s1_act  <= upd_value_i;
    byp_ent <= nxt_ent;
    if (rst) begin
      s1_v         <= 1'b0;
      byp_hit      <= 1'b0;
      pred_valid_o <= 1'b0;
      pred_value_o <= '0;
      pred_conf_o  <= '0;
      pred_hi_o    <= 1'b0;
    end else begin
      s1_v         <= accept;
      byp_hit      <= accept & s1_v & (s1_idx == rd_idx);
      pred_valid_o <= s1_v;
      if (s1_v) begin
        pred_value_o <= nxt_pred;
        pred_conf_o  <= nxt_ent.conf;
        pred_hi_o    <= nxt_hi;
      end
    end
  end
endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
  parameter int IDX_W = 12,
  parameter int HI_TH = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       clr_i,
  input logic       ready_o,
  input logic       upd_valid_i,
  input logic       pred_valid_o,
  input logic [1:0] pred_conf_o,
  input logic       pred_hi_o,
  input logic       s1_v,
  input logic [1:0] cur_conf
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W:0] busy_cnt;
  logic [1:0]     prev_conf;
  logic           step_ok;
  logic           acc;

  assign acc = upd_valid_i & ready_o & ~clr_i;

  always_ff @(posedge clk) begin
    prev_conf <= cur_conf;
    if (rst || ready_o || clr_i) busy_cnt <= '0;
    else                         busy_cnt <= busy_cnt + 1'b1;
  end

  always_comb begin
    case (prev_conf)
      2'd0:    step_ok = (pred_conf_o == 2'd0) || (pred_conf_o == 2'd1);
      2'd3:    step_ok = (pred_conf_o == 2'd3) || (pred_conf_o == 2'd2);
      default: step_ok = (pred_conf_o == prev_conf + 2'd1) ||
                         (pred_conf_o == prev_conf - 2'd1);
    endcase
  end

  // R2
  a_r2_result_latency: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##2 pred_valid_o);

  // R2
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !acc |-> ##2 !pred_valid_o);

  // R1
  a_r1_sweep_length: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> busy_cnt == (IDX_W+1)'(DEPTH));

  // R1
  a_r1_clear_blocks: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !ready_o);

  // R10
  a_r10_clear_drops_update: assert property (@(posedge clk) disable iff (rst)
    clr_i |-> ##2 !pred_valid_o);

  // R6
  a_r6_conf_single_step: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> step_ok);

  // R7
  a_r7_flag_matches_level: assert property (@(posedge clk) disable iff (rst)
    pred_valid_o |-> (pred_hi_o == (pred_conf_o >= 2'(HI_TH))));
endmodule

bind stride2d_vpred vp_checker #(.IDX_W(IDX_W), .HI_TH(HI_TH)) u_vp_checker (
  .clk         (clk),
  .rst         (rst),
  .clr_i       (clr_i),
  .ready_o     (ready_o),
  .upd_valid_i (upd_valid_i),
  .pred_valid_o(pred_valid_o),
  .pred_conf_o (pred_conf_o),
  .pred_hi_o   (pred_hi_o),
  .s1_v        (s1_v),
  .cur_conf    (cur_conf)
);

// File: tb/tb_stride2d_vpred.sv
module tb_stride2d_vpred;
  localparam int CLK_P   = 10;
  localparam int DATA_W  = 32;
  localparam int PC_W    = 16;
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 12;
  localparam int DIST    = 4;
  localparam int HI_TH   = 3;
  localparam int DEPTH   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clr_i = 1'b0;
  logic              ready_o;
  logic              upd_valid_i = 1'b0;
  logic [PC_W-1:0]   upd_pc_i = '0;
  logic [DATA_W-1:0] upd_value_i = '0;
  logic              pred_valid_o;
  logic [DATA_W-1:0] pred_value_o;
  logic [1:0]        pred_conf_o;
  logic              pred_hi_o;

  stride2d_vpred #(.DATA_W(DATA_W), .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W),
                   .DIST(DIST), .HI_TH(HI_TH)) dut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .ready_o(ready_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_value_i(upd_value_i),
    .pred_valid_o(pred_valid_o), .pred_value_o(pred_value_o),
    .pred_conf_o(pred_conf_o), .pred_hi_o(pred_hi_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [DATA_W-1:0] val;
    logic [1:0]        conf;
    logic              hi;
    string             req;
  } exp_t;

  typedef struct {
    logic [DATA_W-1:0] last;
    logic [DATA_W-1:0] delta;
    logic [DATA_W-1:0] stride;
    logic [1:0]        conf;
  } ment_t;

  exp_t  sb_q[$];
  ment_t mdl[int];
  int    checks = 0;
  int    fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: computes the expected result from the requirements and queues it.
  task automatic upd(input logic [PC_W-1:0] pc, input logic [DATA_W-1:0] v,
                     input string req);
    int                k;
    ment_t             e;
    logic [DATA_W-1:0] d;
    exp_t              x;
    k = int'(pc[IDX_LSB +: IDX_W]);                  // R8 index slice
    if (mdl.exists(k)) e = mdl[k];
    else e = '{last: '0, delta: '0, stride: '0, conf: 2'd0};
    d = v - e.last;                                   // R4
    if (v == e.last + e.stride) e.conf = (e.conf == 2'd3) ? 2'd3 : e.conf + 2'd1; // R6
    else                        e.conf = (e.conf == 2'd0) ? 2'd0 : e.conf - 2'd1;
    if (d == e.delta) e.stride = d;
    e.delta = d;
    e.last  = v;
    mdl[k]  = e;
    x.val  = v + e.stride * DATA_W'(DIST);            // R5
    x.conf = e.conf;
    x.hi   = (e.conf >= 2'(HI_TH));                   // R7
    x.req  = req;
    sb_q.push_back(x);
    upd_valid_i = 1'b1;
    upd_pc_i    = pc;
    upd_value_i = v;
    @(negedge clk);
    upd_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R1: count not-ready cycles while offering updates that must be ignored.
  task automatic wait_sweep(input string req);
    int n;
    n = 0;
    upd_pc_i    = 16'h0ABC;
    upd_value_i = 32'hDEAD_0001;
    upd_valid_i = 1'b1;
    while (!ready_o && n < DEPTH + 20) begin
      @(negedge clk);
      n++;
      upd_value_i = upd_value_i + 32'd7;
    end
    upd_valid_i = 1'b0;
    check(n == DEPTH, req, "sweep length", 64'(n), 64'(DEPTH));
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && pred_valid_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected result", 64'(pred_value_o), 64'(0));
        end else begin
          exp_t x;
          x = sb_q.pop_front();
          check(pred_value_o == x.val && pred_conf_o == x.conf && pred_hi_o == x.hi,
                x.req, "value/conf/hi", {27'd0, pred_value_o, pred_conf_o, pred_hi_o},
                {27'd0, x.val, x.conf, x.hi});
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [PC_W-1:0] PC_A  = 16'h0040;
  localparam logic [PC_W-1:0] PC_A2 = 16'hC043;   // same index as PC_A
  localparam logic [PC_W-1:0] PC_B  = 16'h0104;
  localparam logic [PC_W-1:0] PC_C  = 16'h2000;
  localparam logic [PC_W-1:0] PC_D  = 16'h3FFC;
  localparam logic [PC_W-1:0] PC_E  = 16'h0044;   // neighbour of PC_A

  initial begin
    // Reset state (R1, R2)
    idle(3);
    check(ready_o == 1'b0, "R1", "ready during reset", 64'(ready_o), 64'(0));
    check(pred_valid_o == 1'b0, "R2", "valid during reset", 64'(pred_valid_o), 64'(0));
    rst = 1'b0;
    wait_sweep("R1");

    // R3: fresh entry
    upd(PC_A, 32'd100, "R3");
    idle(3);
    // R4/R6/R7: two-delta stride commit and confidence climb (spaced)
    upd(PC_A, 32'd110, "R4");
    idle(2);
    upd(PC_A, 32'd120, "R4");
    idle(2);
    upd(PC_A, 32'd130, "R6");
    idle(2);
    upd(PC_A, 32'd140, "R6");
    idle(2);
    upd(PC_A, 32'd150, "R7");
    idle(2);
    upd(PC_A, 32'd160, "R6");
    idle(2);
    // A single odd delta must not replace the stride (R4)
    upd(PC_A, 32'd200, "R4");
    idle(1);
    upd(PC_A, 32'd210, "R4");
    idle(3);

    // R6: saturation at zero with irregular values
    upd(PC_B, 32'h1234_5678, "R6");
    upd(PC_B, 32'h0000_0003, "R6");
    upd(PC_B, 32'h7777_0000, "R6");
    idle(3);

    // R5: wraparound and negative stride
    upd(PC_C, 32'hFFFF_FFF0, "R5");
    upd(PC_C, 32'hFFFF_FFF8, "R5");
    upd(PC_C, 32'h0000_0000, "R5");
    upd(PC_C, 32'h0000_0008, "R5");
    idle(2);
    upd(PC_D, 32'd1000, "R5");
    upd(PC_D, 32'd990, "R5");
    upd(PC_D, 32'd980, "R5");
    upd(PC_D, 32'd970, "R5");
    idle(3);

    // R8: aliasing program counters and an independent neighbour
    upd(PC_A2, 32'd220, "R8");
    upd(PC_E, 32'd5, "R8");
    upd(PC_A, 32'd230, "R8");
    upd(PC_E, 32'd9, "R8");
    upd(PC_A2, 32'd240, "R8");
    upd(PC_E, 32'd13, "R8");
    upd(PC_E, 32'd17, "R8");
    idle(3);

    // R9: same entry back-to-back, then one idle cycle apart
    for (int i = 0; i < 6; i++) upd(PC_B, 32'd50 + 32'(i) * 32'd3, "R9");
    for (int i = 0; i < 4; i++) begin
      upd(PC_B, 32'd80 + 32'(i) * 32'd3, "R9");
      idle(1);
    end
    idle(3);

    // R10: update in the clear cycle, then the sweep (R1)
    clr_i       = 1'b1;
    upd_valid_i = 1'b1;
    upd_pc_i    = PC_A;
    upd_value_i = 32'h5555_5555;
    @(negedge clk);
    clr_i       = 1'b0;
    upd_valid_i = 1'b0;
    mdl.delete();
    check(ready_o == 1'b0, "R1", "ready after clear", 64'(ready_o), 64'(0));
    check(pred_valid_o == 1'b0, "R10", "result in clear", 64'(pred_valid_o), 64'(0));
    wait_sweep("R1");

    // Cleared entries behave as fresh; ignored updates left nothing (R1, R10)
    upd(PC_A, 32'd500, "R10");
    upd(16'h0ABC, 32'd42, "R1");
    upd(PC_A, 32'd505, "R3");
    idle(5);

    check(sb_q.size() == 0, "R2", "results outstanding", 64'(sb_q.size()), 64'(0));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule